// File: doc/BRIEF.md
# Stepper-Driven Band Switch Controller

This block positions a rotary band switch that a two-phase stepper motor turns. A command carries a 5-bit band code and a transmit/receive mode flag. The block decodes the held code into 25 active-low band select lines and an invalid-code flag. It compares the new code with a stored present position to choose a rotation direction. It then issues one full step on each slow step-clock enable until the position feedback input reports that the target band is reached.

While the motor turns, the command port reports not ready, so new commands are held off. A step-count watchdog stops a motor that never reaches its target and raises an active-low timeout flag. When a move ends on feedback, the target code becomes the new present position. The command port follows valid/ready rules. A command is taken on a rising clock edge where `cmd_valid` and `cmd_ready` are both high. While `cmd_ready` is low, the sender must hold its command; a command offered in that time has no effect. `cmd_ready` depends only on internal state and never on `cmd_valid`.

Top module: `band_switch_ctrl`

## Requirements
- R1: The held code drives `band_n`. For a held code c in 0..24, only bit c is low. For 25..31, all 25 bits are high and `invalid_addr` is 1; otherwise `invalid_addr` is 0.
- R2: An accepted command whose code is 25..31 starts no motion. `cmd_ready` stays 1 and the phase outputs do not change.
- R3: A command is accepted on a rising edge with `cmd_valid`=1 and `cmd_ready`=1. It is latched as the held code and, for a valid differing code, `cmd_ready` is 0 from the next cycle. A command offered while `cmd_ready` is 0 leaves the held code unchanged.
- R4: `motor_fwd` becomes 1 on a move to a code greater than the present position and 0 on a move to a smaller code.
- R5: While moving, each `step_en` cycle without feedback advances the phase state (A,B)=(`ph_a1`,`ph_b1`). Forward order is 00,01,11,10,00; reverse order is the opposite. `ph_a2` is the inverse of `ph_a1` and `ph_b2` is the inverse of `ph_b1`. While idle, `step_en` does not change the phases.
- R6: While moving, a `step_en` cycle with `fb_n`=0 takes no step, and `cmd_ready` is 1 on the next cycle.
- R7: A move that ends on feedback stores its code as the present position. A valid command equal to the present position starts no motion, and `cmd_ready` stays 1.
- R8: Each accepted command clears the step counter and sets `timeout_n` to 1. After 255 steps without feedback, the next `step_en` sets `timeout_n` to 0 and takes no step. `cmd_ready` then returns to 1 and the present position is left unchanged.
- R9: After reset: `cmd_ready`=1, `timeout_n`=1, (`ph_a1`,`ph_a2`,`ph_b1`,`ph_b2`)=0,1,0,1, present position 0, held code 0 (`band_n[0]` low), `tx_mode`=0.
- R10: `tx_mode` holds the `cmd_tx` value of the most recently accepted command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low power-on reset |
| step_en | input | 1 | One-cycle step-clock enable (slow step rate) |
| cmd_valid | input | 1 | Command offered |
| cmd_code | input | 5 | Requested band code |
| cmd_tx | input | 1 | Mode flag: 1 transmit, 0 receive |
| cmd_ready | output | 1 | High when idle and able to accept a command |
| fb_n | input | 1 | Active-low position feedback from the selected band line |
| band_n | output | 25 | Active-low one-cold band select lines |
| invalid_addr | output | 1 | Held code is outside 0..24 |
| motor_fwd | output | 1 | Direction of the current or last move |
| tx_mode | output | 1 | Latched mode flag |
| timeout_n | output | 1 | Active-low step-count timeout |
| ph_a1 | output | 1 | Phase A drive |
| ph_a2 | output | 1 | Phase A complement |
| ph_b1 | output | 1 | Phase B drive |
| ph_b2 | output | 1 | Phase B complement |

## Verification
On every cycle, the assertions check the following. The phase pair changes by at most one bit. The decoder output is one-cold for valid codes and all high otherwise. The held code stays fixed while a move is in progress. A raised timeout leaves the block idle, and an invalid command never starts motion. Other behaviour needs the bench scenarios. These are the direction chosen from the stored position, that the stored position changes only when a move ends on feedback, the exact 255-step timeout boundary, and the latched mode flag.

// File: rtl/bsw_pkg.sv
package bsw_pkg;

  typedef enum logic [0:0] {
    MV_IDLE = 1'b0,
    MV_RUN  = 1'b1
  } mv_state_t;

  // Map a phase index onto the (A,B) drive pair: 0->00, 1->01, 2->11, 3->10
  function automatic logic [1:0] phase_ab(input logic [1:0] idx);
    phase_ab = {idx[1], idx[1] ^ idx[0]};
  endfunction

  function automatic logic [1:0] phase_step(input logic [1:0] idx, input logic fwd);
    phase_step = fwd ? idx + 2'd1 : idx - 2'd1;
  endfunction

endpackage

// File: rtl/band_decoder.sv
module band_decoder #(
  parameter int CODE_W    = 5,
  parameter int NUM_BANDS = 25
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [CODE_W-1:0]    code,
  output logic [NUM_BANDS-1:0] band_n,
  output logic                 invalid
);
  localparam logic [CODE_W-1:0] LAST_BAND = CODE_W'(NUM_BANDS - 1);

  for (genvar gi = 0; gi < NUM_BANDS; gi++) begin : g_line
    assign band_n[gi] = (code != CODE_W'(gi));
  end

  assign invalid = (code > LAST_BAND);

  AST_ONE_COLD: assert property (@(posedge clk) disable iff (!rst_n)
    (code <= LAST_BAND) |-> ($countones(~band_n) == 1 && !invalid)) // R1
    else $error("decoder not one-cold");

  AST_INVALID_ALL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    invalid |-> (&band_n)) // R1
    else $error("band line low for invalid code");

endmodule

// File: rtl/step_sequencer.sv
module step_sequencer
  import bsw_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic adv,
  input  logic fwd,
  output logic a1,
  output logic a2,
  output logic b1,
  output logic b2
);
  logic [1:0] idx_q;
  logic [1:0] ab;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   idx_q <= 2'd0;
    else if (adv) idx_q <= phase_step(idx_q, fwd);
  end

  assign ab = phase_ab(idx_q);
  assign a1 = ab[1];
  assign a2 = ~ab[1];
  assign b1 = ab[0];
  assign b2 = ~ab[0];

  AST_FULL_STEP_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({a1, b1} ^ $past({a1, b1})) <= 1) // R5
    else $error("phase jumped by more than one step");

  AST_HOLD_WITHOUT_ADV: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable({a1, b1})) // R5
    else $error("phase moved without advance");

endmodule

// File: rtl/step_timer.sv
module step_timer #(
  parameter int TMO_W = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  output logic full
);
  logic [TMO_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt_q <= '0;
    else if (clr) cnt_q <= '0;
    else if (inc) cnt_q <= cnt_q + 1'b1;
  end

  assign full = &cnt_q;

  AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !clr) |=> full) // R8
    else $error("step counter wrapped");

endmodule

// File: rtl/motion_ctrl.sv
module motion_ctrl
  import bsw_pkg::*;
#(
  parameter int CODE_W    = 5,
  parameter int NUM_BANDS = 25
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_en,
  input  logic              cmd_valid,
  input  logic [CODE_W-1:0] cmd_code,
  input  logic              cmd_tx,
  input  logic              fb_n,
  input  logic              cnt_full,
  output logic              cmd_ready,
  output logic [CODE_W-1:0] held_code,
  output logic              motor_fwd,
  output logic              tx_mode,
  output logic              timeout_n,
  output logic              step_adv,
  output logic              cnt_clr
);
  localparam logic [CODE_W-1:0] LAST_BAND = CODE_W'(NUM_BANDS - 1);

  mv_state_t         state_q;
  logic [CODE_W-1:0] pos_q;
  logic              accept;
  logic              cmd_bad;

  assign cmd_ready = (state_q == MV_IDLE);
  assign accept    = cmd_valid && cmd_ready;
  assign cmd_bad   = (cmd_code > LAST_BAND);
  assign step_adv  = (state_q == MV_RUN) && step_en && fb_n && !cnt_full;
  assign cnt_clr   = accept;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= MV_IDLE;
      held_code <= '0;
      pos_q     <= '0;
      motor_fwd <= 1'b0;
      tx_mode   <= 1'b0;
      timeout_n <= 1'b1;
    end else begin
      case (state_q)
        MV_IDLE: begin
          if (accept) begin
            held_code <= cmd_code;
            tx_mode   <= cmd_tx;
            timeout_n <= 1'b1;
            if (!cmd_bad && cmd_code != pos_q) begin
              state_q   <= MV_RUN;
              motor_fwd <= (cmd_code > pos_q);
            end
          end
        end
        MV_RUN: begin
          if (step_en) begin
            if (!fb_n) begin
              state_q <= MV_IDLE;
              pos_q   <= held_code;
            end else if (cnt_full) begin
              state_q   <= MV_IDLE;
              timeout_n <= 1'b0;
            end
          end
        end
        default: state_q <= MV_IDLE;
      endcase
    end
  end

  AST_HOLD_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == MV_RUN) |=> $stable(held_code)) // R3
    else $error("held code changed during motion");

  AST_BAD_CODE_NO_MOTION: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && cmd_bad) |=> cmd_ready) // R2
    else $error("invalid code started motion");

  AST_TIMEOUT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !timeout_n |-> cmd_ready) // R8
    else $error("timeout raised while moving");

  AST_POS_ONLY_ON_FEEDBACK: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pos_q) |-> $past(!fb_n && step_en && state_q == MV_RUN)) // R7
    else $error("position changed without feedback");

endmodule

// File: rtl/band_switch_ctrl.sv
module band_switch_ctrl #(
  parameter int CODE_W    = 5,
  parameter int NUM_BANDS = 25,
  parameter int TMO_W     = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 step_en,
  input  logic                 cmd_valid,
  input  logic [CODE_W-1:0]    cmd_code,
  input  logic                 cmd_tx,
  output logic                 cmd_ready,
  input  logic                 fb_n,
  output logic [NUM_BANDS-1:0] band_n,
  output logic                 invalid_addr,
  output logic                 motor_fwd,
  output logic                 tx_mode,
  output logic                 timeout_n,
  output logic                 ph_a1,
  output logic                 ph_a2,
  output logic                 ph_b1,
  output logic                 ph_b2
);
  logic [CODE_W-1:0] held_code;
  logic              step_adv;
  logic              cnt_clr;
  logic              cnt_full;

  motion_ctrl #(.CODE_W(CODE_W), .NUM_BANDS(NUM_BANDS)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .step_en   (step_en),
    .cmd_valid (cmd_valid),
    .cmd_code  (cmd_code),
    .cmd_tx    (cmd_tx),
    .fb_n      (fb_n),
    .cnt_full  (cnt_full),
    .cmd_ready (cmd_ready),
    .held_code (held_code),
    .motor_fwd (motor_fwd),
    .tx_mode   (tx_mode),
    .timeout_n (timeout_n),
    .step_adv  (step_adv),
    .cnt_clr   (cnt_clr)
  );

  band_decoder #(.CODE_W(CODE_W), .NUM_BANDS(NUM_BANDS)) u_dec (
    .clk     (clk),
    .rst_n   (rst_n),
    .code    (held_code),
    .band_n  (band_n),
    .invalid (invalid_addr)
  );

  step_timer #(.TMO_W(TMO_W)) u_tmr (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (cnt_clr),
    .inc   (step_adv),
    .full  (cnt_full)
  );

  step_sequencer u_seq (
    .clk   (clk),
    .rst_n (rst_n),
    .adv   (step_adv),
    .fwd   (motor_fwd),
    .a1    (ph_a1),
    .a2    (ph_a2),
    .b1    (ph_b1),
    .b2    (ph_b2)
  );

  AST_NO_STEP_WHEN_READY: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |=> $stable({ph_a1, ph_b1})) // R5
    else $error("phases moved while idle");

endmodule

// File: tb/band_switch_ctrl_test.sv
module band_switch_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        step_en = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [4:0]  cmd_code = '0;
  logic        cmd_tx = 1'b0;
  logic        fb_n = 1'b1;
  logic        cmd_ready, invalid_addr, motor_fwd, tx_mode, timeout_n;
  logic        ph_a1, ph_a2, ph_b1, ph_b2;
  logic [24:0] band_n;

  int n_chk = 0;
  int n_bad = 0;
  logic [1:0] ei = 2'd0;  // expected phase index

  always #10 clk = ~clk;

  band_switch_ctrl uut (
    .clk(clk), .rst_n(rst_n), .step_en(step_en), .cmd_valid(cmd_valid),
    .cmd_code(cmd_code), .cmd_tx(cmd_tx), .cmd_ready(cmd_ready), .fb_n(fb_n),
    .band_n(band_n), .invalid_addr(invalid_addr), .motor_fwd(motor_fwd),
    .tx_mode(tx_mode), .timeout_n(timeout_n),
    .ph_a1(ph_a1), .ph_a2(ph_a2), .ph_b1(ph_b1), .ph_b2(ph_b2)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_ph(input logic [1:0] i);
    logic a, b;
    a = i[1];
    b = i[1] ^ i[0];
    return {a, ~a, b, ~b};
  endfunction

  function automatic logic [24:0] exp_band(input int c);
    logic [24:0] v = '1;
    if (c < 25) v[c] = 1'b0;
    return v;
  endfunction

  task automatic send(input logic [4:0] c, input logic tx);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_code = c; cmd_tx = tx;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic pulse_step();
    @(negedge clk);
    step_en = 1'b1;
    @(negedge clk);
    step_en = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  // Move to code c, taking n steps, then end on feedback
  task automatic t_move(input logic [4:0] c, input int n, input logic fwd, input logic tx);
    send(c, tx);
    chk("R3 ready low while moving", cmd_ready, 0);
    chk("R4 direction", motor_fwd, fwd);
    chk("R1 band line", band_n, exp_band(c));
    chk("R10 tx mode", tx_mode, tx);
    for (int k = 0; k < n; k++) begin
      pulse_step();
      ei = fwd ? ei + 2'd1 : ei - 2'd1;
      chk("R5 phase step", {ph_a1, ph_a2, ph_b1, ph_b2}, exp_ph(ei));
    end
    fb_n = 1'b0;
    pulse_step();
    fb_n = 1'b1;
    chk("R6 ready after feedback", cmd_ready, 1);
    chk("R6 no step on feedback", {ph_a1, ph_a2, ph_b1, ph_b2}, exp_ph(ei));
  endtask

  task automatic t_reset();
    chk("R9 ready", cmd_ready, 1);
    chk("R9 timeout_n", timeout_n, 1);
    chk("R9 phases", {ph_a1, ph_a2, ph_b1, ph_b2}, 4'b0101);
    chk("R9 band", band_n, exp_band(0));
    chk("R9 invalid", invalid_addr, 0);
    chk("R9 tx_mode", tx_mode, 0);
  endtask

  task automatic t_idle_steps();
    repeat (3) pulse_step();
    chk("R5 idle step ignored", {ph_a1, ph_a2, ph_b1, ph_b2}, exp_ph(ei));
  endtask

  task automatic t_equal(input logic [4:0] c, input logic tx);
    send(c, tx);
    chk("R7 equal code no motion", cmd_ready, 1);
    chk("R10 tx latched", tx_mode, tx);
    pulse_step();
    chk("R7 phases unchanged", {ph_a1, ph_a2, ph_b1, ph_b2}, exp_ph(ei));
  endtask

  task automatic t_busy_ignore();
    send(5'd7, 1'b0);  // pos is 0 -> forward move
    chk("R3 busy", cmd_ready, 0);
    send(5'd2, 1'b1);  // offered while busy
    chk("R3 ignored code", band_n, exp_band(7));
    chk("R3 ignored tx", tx_mode, 0);
    pulse_step();
    ei = ei + 2'd1;
    fb_n = 1'b0;
    pulse_step();
    fb_n = 1'b1;
    chk("R3 done", cmd_ready, 1);
  endtask

  task automatic t_invalid(input logic [4:0] c);
    send(c, 1'b0);
    chk("R2 ready stays high", cmd_ready, 1);
    chk("R1 invalid flag", invalid_addr, 1);
    chk("R1 all lines high", band_n, exp_band(c));
    pulse_step();
    chk("R2 phases unchanged", {ph_a1, ph_a2, ph_b1, ph_b2}, exp_ph(ei));
  endtask

  task automatic t_timeout();
    send(5'd10, 1'b0);  // pos is 24 -> reverse
    chk("R4 reverse", motor_fwd, 0);
    for (int k = 0; k < 255; k++) begin
      pulse_step();
      ei = ei - 2'd1;
    end
    chk("R8 still moving at 255", cmd_ready, 0);
    chk("R8 no timeout at 255", timeout_n, 1);
    chk("R8 phase at 255", {ph_a1, ph_a2, ph_b1, ph_b2}, exp_ph(ei));
    pulse_step();
    chk("R8 timeout_n low", timeout_n, 0);
    chk("R8 ready after timeout", cmd_ready, 1);
    chk("R8 no step on timeout", {ph_a1, ph_a2, ph_b1, ph_b2}, exp_ph(ei));
    // position must still be 24: same code moves again, reverse
    send(5'd10, 1'b1);
    chk("R8 position kept", cmd_ready, 0);
    chk("R8 direction from old pos", motor_fwd, 0);
    chk("R8 timeout cleared", timeout_n, 1);
    pulse_step();
    ei = ei - 2'd1;
    fb_n = 1'b0;
    pulse_step();
    fb_n = 1'b1;
    chk("R7 move done", cmd_ready, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_idle_steps();
    t_equal(5'd0, 1'b1);
    t_busy_ignore();                    // pos 7
    t_move(5'd3, 3, 1'b0, 1'b0);        // reverse to 3
    t_move(5'd24, 5, 1'b1, 1'b1);       // forward to 24
    t_invalid(5'd25);
    t_invalid(5'd31);
    t_equal(5'd24, 1'b0);               // R7 position 24 survived invalids
    t_timeout();                        // ends at pos 10
    t_equal(5'd10, 1'b1);
    t_move(5'd11, 2, 1'b1, 1'b0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule